// File: doc/BRIEF.md
# Two-Cycle Reflected CRC Folding Unit

This block performs one folding step of a reflected CRC over the low 8, 16 or 32 bits of a 32-bit operand. The operand holds the running CRC with the next message chunk already XORed into its low bits. The step returns the updated 32-bit remainder. Two generator polynomials are available per operation: CRC-32 (generator 0x04C11DB7) and CRC-32C (generator 0x1EDC6F41). In reflected form, each step is the same as shifting the operand right once per consumed bit and XORing in the reflected generator whenever the bit that falls out is one.

The unit does not shift bit by bit. It computes the remainder by Barrett reduction. A first carry-less multiply by the precomputed quotient constant of x^64 divided by the generator is registered at the end of the request cycle. A second carry-less multiply by the generator, followed by the final XOR with the shifted-down upper operand bits, is registered one cycle later. The unit applies no initial value and no final inversion; the caller adds them. Longer messages are handled by calling the unit again with the previous result, one chunk at a time.

Requests use a valid/ready pair. The unit is ready whenever the first stage is empty. A request offered while ready is low is dropped, not stalled. The result side is a one-cycle done pulse without back-pressure. The result stays on its port until the next done pulse.

Top module: `crc_fold_unit`

## Requirements
- R1: While reset is asserted and after its release, `done_o` is 0, `result_o` is 0 and `req_ready_o` is 1 until the first request.
- R2: A request is accepted on a rising clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 during the cycle that follows acceptance and returns to 1 one cycle later.
- R3: `done_o` is 1 for exactly one cycle: the second cycle after the acceptance edge. It is never high without an acceptance two edges earlier.
- R4: A request offered while `req_ready_o` is 0 is ignored. It produces no done pulse and does not change the result of the operation in flight.
- R5: With `req_poly_i` = 0, the result equals the bit-serial reflected CRC-32 step with reflected generator 0xEDB88320, applied once per consumed bit.
- R6: With `req_poly_i` = 1, the result equals the bit-serial reflected step with reflected generator 0x82F63B78 (CRC-32C).
- R7: `req_size_i` selects the number of consumed low bits n: 2'b00 gives 8, 2'b01 gives 16, and 2'b10 and 2'b11 both give 32.
- R8: For n of 8 or 16, operand bits at and above n reach the result shifted down by n and XORed with the reduced low part. An operand whose low n bits are zero yields exactly operand >> n.
- R9: No initial value or output inversion is applied. An all-zero operand gives an all-zero result for every size and polynomial.
- R10: `result_o` keeps its value in every cycle in which `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Unit can accept a request this cycle |
| req_data_i | input | 32 | Operand: running CRC XOR next chunk |
| req_size_i | input | 2 | Chunk size select (byte, half, word) |
| req_poly_i | input | 1 | 0 selects CRC-32, 1 selects CRC-32C |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | 32 | Updated remainder, held until next done |

## Verification
The latency and hold properties assume that `req_valid_i` and the request fields settle away from the clock edge. They also assume that an offer made while the unit is busy is simply lost, so the requester never relies on stalling. The stimulus changes inputs only at falling edges. It offers a second request only in the busy cycle, to exercise the drop rule, and withdraws it before the unit is ready again. Random operands, sizes and polynomials come from a fixed seed. Directed zero, all-ones, single-bit and upper-bits-only operands cover the cases where the reduction carries no work or only one term.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;

  localparam int unsigned CRC_W = 32;

  typedef enum logic [1:0] {
    CHUNK_8   = 2'b00,
    CHUNK_16  = 2'b01,
    CHUNK_32  = 2'b10,
    CHUNK_32B = 2'b11
  } chunk_e;

  // number of low operand bits consumed for a size code
  function automatic logic [5:0] chunk_len(input logic [1:0] code);
    case (chunk_e'(code))
      CHUNK_8:  chunk_len = 6'd8;
      CHUNK_16: chunk_len = 6'd16;
      default:  chunk_len = 6'd32;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
    for (int i = 0; i < CRC_W; i++) bit_rev[i] = v[CRC_W-1-i];
  endfunction

  // quotient of x^(2W) by {1,gen}; the leading x^W term is dropped
  function automatic logic [CRC_W-1:0] barrett_const(input logic [CRC_W-1:0] gen);
    logic [CRC_W:0]   win;
    logic [CRC_W-1:0] quo;
    win = '0;
    quo = '0;
    for (int i = 2 * CRC_W; i >= 0; i--) begin
      win = {win[CRC_W-1:0], (i == 2 * CRC_W)};
      if (win[CRC_W]) begin
        win = win ^ {1'b1, gen};
        if (i < CRC_W) quo[i] = 1'b1;
      end
    end
    barrett_const = quo;
  endfunction

endpackage

// File: rtl/crc_clmul_window.sv
// Carry-less product of a and b, returning only bits [LO +: OW].
module crc_clmul_window #(
  parameter int unsigned AW = 32,
  parameter int unsigned BW = 32,
  parameter int unsigned LO = 0,
  parameter int unsigned OW = 32
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [OW-1:0] p_o
);

  for (genvar k = 0; k < OW; k++) begin : g_bit
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int i = 0; i < BW; i++) begin
        if ((int'(k + LO) - i) >= 0 && (int'(k + LO) - i) < int'(AW))
          acc = acc ^ (a_i[int'(k + LO) - i] & b_i[i]);
      end
    end
    assign p_o[k] = acc;
  end

endmodule

// File: rtl/crc_fold_front.sv
// Cycle 0: reflect the consumed chunk, estimate the Barrett quotient.
module crc_fold_front
  import crc_fold_pkg::*;
#(
  parameter logic [CRC_W-1:0] GEN_A = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] GEN_B = 32'h1EDC_6F41
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CRC_W-1:0] data_i,
  input  logic [1:0]       size_i,
  input  logic             poly_i,
  output logic             s0_valid_o,
  output logic [CRC_W-1:0] s0_quo_o,
  output logic [CRC_W-1:0] s0_keep_o,
  output logic             s0_poly_o
);

  localparam logic [CRC_W-1:0] MU_A = barrett_const(GEN_A);
  localparam logic [CRC_W-1:0] MU_B = barrett_const(GEN_B);

  logic [5:0]       nbits;
  logic [CRC_W-1:0] chunk_rev;
  logic [CRC_W-1:0] mu_sel;
  logic [CRC_W-2:0] quo_hi;
  logic [CRC_W-1:0] quo;

  assign nbits     = chunk_len(size_i);
  assign chunk_rev = bit_rev(data_i << (6'(CRC_W) - nbits));
  assign mu_sel    = poly_i ? MU_B : MU_A;

  crc_clmul_window #(
    .AW(CRC_W), .BW(CRC_W), .LO(CRC_W), .OW(CRC_W-1)
  ) u_mul_mu (
    .a_i(chunk_rev),
    .b_i(mu_sel),
    .p_o(quo_hi)
  );

  assign quo = chunk_rev ^ {1'b0, quo_hi};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_valid_o <= 1'b0;
      s0_quo_o   <= '0;
      s0_keep_o  <= '0;
      s0_poly_o  <= 1'b0;
    end else begin
      s0_valid_o <= take_i;
      if (take_i) begin
        s0_quo_o  <= quo;
        s0_keep_o <= data_i >> nbits;
        s0_poly_o <= poly_i;
      end
    end
  end

endmodule

// File: rtl/crc_fold_back.sv
// Cycle 1: remainder = low word of quotient times generator, then merge.
module crc_fold_back
  import crc_fold_pkg::*;
#(
  parameter logic [CRC_W-1:0] GEN_A = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] GEN_B = 32'h1EDC_6F41
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s0_valid_i,
  input  logic [CRC_W-1:0] s0_quo_i,
  input  logic [CRC_W-1:0] s0_keep_i,
  input  logic             s0_poly_i,
  output logic             done_o,
  output logic [CRC_W-1:0] result_o
);

  logic [CRC_W-1:0] gen_sel;
  logic [CRC_W-1:0] rem;

  assign gen_sel = s0_poly_i ? GEN_B : GEN_A;

  crc_clmul_window #(
    .AW(CRC_W), .BW(CRC_W), .LO(0), .OW(CRC_W)
  ) u_mul_gen (
    .a_i(s0_quo_i),
    .b_i(gen_sel),
    .p_o(rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= s0_valid_i;
      if (s0_valid_i) result_o <= s0_keep_i ^ bit_rev(rem);
    end
  end

endmodule

// File: rtl/crc_fold_unit.sv
module crc_fold_unit
  import crc_fold_pkg::*;
#(
  parameter logic [CRC_W-1:0] GEN_A = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] GEN_B = 32'h1EDC_6F41
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [CRC_W-1:0] req_data_i,
  input  logic [1:0]       req_size_i,
  input  logic             req_poly_i,
  output logic             done_o,
  output logic [CRC_W-1:0] result_o
);

  logic             take;
  logic             s0_valid;
  logic [CRC_W-1:0] s0_quo;
  logic [CRC_W-1:0] s0_keep;
  logic             s0_poly;

  assign req_ready_o = !s0_valid;
  assign take        = req_valid_i && req_ready_o;

  crc_fold_front #(.GEN_A(GEN_A), .GEN_B(GEN_B)) u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .data_i    (req_data_i),
    .size_i    (req_size_i),
    .poly_i    (req_poly_i),
    .s0_valid_o(s0_valid),
    .s0_quo_o  (s0_quo),
    .s0_keep_o (s0_keep),
    .s0_poly_o (s0_poly)
  );

  crc_fold_back #(.GEN_A(GEN_A), .GEN_B(GEN_B)) u_back (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s0_valid_i(s0_valid),
    .s0_quo_i  (s0_quo),
    .s0_keep_i (s0_keep),
    .s0_poly_i (s0_poly),
    .done_o    (done_o),
    .result_o  (result_o)
  );

endmodule

// File: rtl/crc_fold_unit_chk.sv
module crc_fold_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic [31:0] result_o
);

  logic seen1, seen2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen1 <= 1'b0;
      seen2 <= 1'b0;
    end else begin
      seen1 <= 1'b1;
      seen2 <= seen1;
    end
  end

  assert_busy_after_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_done_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen2 && $past(req_valid_i && req_ready_o, 2)) |-> done_o);

  assert_done_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen2 && done_o) |-> $past(req_valid_i && req_ready_o, 2));

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen1 && !done_o) |-> $stable(result_o));

endmodule

bind crc_fold_unit crc_fold_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/crc_fold_unit_test.sv
module crc_fold_unit_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_data_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_poly_i = 1'b0;
  logic        done_o;
  logic [31:0] result_o;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  crc_fold_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_data_i(req_data_i), .req_size_i(req_size_i), .req_poly_i(req_poly_i),
    .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [31:0] ref_step(logic [31:0] v, logic [1:0] sz, logic pol);
    int n;
    logic [31:0] rp;
    n  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;   // R7
    rp = pol ? 32'h82F6_3B78 : 32'hEDB8_8320;           // R5 R6
    for (int i = 0; i < n; i++) v = v[0] ? ((v >> 1) ^ rp) : (v >> 1);
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] op, logic [1:0] sz, logic pol, string tag, bit poke);
    logic [31:0] exp;
    exp = ref_step(op, sz, pol);
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R2 ready before request", 32'(req_ready_o), 32'd1);
    req_valid_i = 1'b1; req_data_i = op; req_size_i = sz; req_poly_i = pol;
    @(negedge clk_i);
    if (poke) begin
      req_valid_i = 1'b1; req_data_i = ~op; req_size_i = 2'b10; req_poly_i = ~pol;
    end else begin
      req_valid_i = 1'b0;
    end
    chk(req_ready_o == 1'b0, "R2 busy after accept", 32'(req_ready_o), 32'd0);
    chk(done_o == 1'b0, "R3 no early done", 32'(done_o), 32'd0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(done_o == 1'b1, "R3 done at second cycle", 32'(done_o), 32'd1);
    chk(result_o == exp, tag, result_o, exp);
    @(negedge clk_i);
    chk(done_o == 1'b0, poke ? "R4 dropped request no done" : "R3 single pulse", 32'(done_o), 32'd0);
    chk(result_o == exp, poke ? "R4 result untouched" : "R10 result held", result_o, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed_v;
    seed_v = $urandom(32'h5EED_0C2C);
    repeat (3) @(negedge clk_i);
    chk(done_o == 1'b0, "R1 done in reset", 32'(done_o), 32'd0);
    chk(result_o == 32'd0, "R1 result in reset", result_o, 32'd0);
    chk(req_ready_o == 1'b1, "R1 ready in reset", 32'(req_ready_o), 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0 && result_o == 32'd0, "R1 idle after reset", result_o, 32'd0);

    // zero operand: no init or final inversion
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++)
        run_op(32'd0, 2'(s), 1'(p), "R9 zero operand", 1'b0);

    // all ones, every size and polynomial
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++)
        run_op(32'hFFFF_FFFF, 2'(s), 1'(p), "R7 all-ones size", 1'b0);

    // single-bit operands
    for (int b = 0; b < 32; b++) begin
      run_op(32'd1 << b, 2'b10, 1'b0, "R5 single bit crc32", 1'b0);
      run_op(32'd1 << b, 2'b10, 1'b1, "R6 single bit crc32c", 1'b0);
    end

    // upper bits only: pure shift
    run_op(32'hA5C3_9E00, 2'b00, 1'b0, "R8 byte upper only", 1'b0);
    chk(result_o == (32'hA5C3_9E00 >> 8), "R8 byte shift", result_o, 32'hA5C3_9E00 >> 8);
    run_op(32'h7F31_0000, 2'b01, 1'b1, "R8 half upper only", 1'b0);
    chk(result_o == (32'h7F31_0000 >> 16), "R8 half shift", result_o, 32'h7F31_0000 >> 16);

    // dropped requests while busy
    run_op(32'h1234_5678, 2'b00, 1'b0, "R4 op with busy poke", 1'b1);
    run_op(32'hDEAD_BEEF, 2'b11, 1'b1, "R4 op with busy poke word", 1'b1);

    // random mix
    for (int k = 0; k < 200; k++) begin
      logic [31:0] v;
      logic [1:0]  sz;
      logic        pl;
      v  = $urandom;
      sz = 2'($urandom_range(0, 3));
      pl = 1'($urandom_range(0, 1));
      run_op(v, sz, pl, pl ? "R6 random crc32c" : "R5 random crc32", 1'b0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule